// File: doc/BRIEF.md
# Transmit DMA Frame Forwarder

This block fetches outgoing frames from memory and hands them to a MAC transmit FIFO. It starts from a descriptor pointer and reads each three-word descriptor. If the descriptor is owned by the DMA, it pulls the frame's data in bursts into a local 64-word buffer. Then it clears the ownership flag in memory and follows the next-descriptor link. A descriptor the DMA does not own is either skipped or halts the walk, and a zero link ends the walk. Both cases are reported through sticky status flags.

Buffered words reach the MAC only after a programmable fill level is met. The end of a frame overrides that wait, and a frame that has begun to drain keeps going for as long as data remains. Four event flags (not-owner, null pointer, control packet sent, buffer empty) are each masked by an enable bit and combined into a single interrupt line.

Top module: `txdma_fwd`

## Requirements
- R1: The 5-bit burst field N (config bits [4:0]) sizes data reads at N+1 words (0 gives 1, 31 gives 32). The last read of a frame is cut to the words still owed, so no read passes the frame length.
- R2: Descriptor layout: word 0 has the DMA-owns flag in bit 31 and the length in words in [15:0], word 1 holds the buffer byte address, and word 2 holds the next-descriptor byte address. Words sit 4 bytes apart. After an owned frame, word 0 is written back with bit 31 cleared and the link is followed. Frame words reach the MAC in address order, with `macLast` on the final one.
- R3: With the stop policy bit (config bit 5) at 0, a descriptor whose bit 31 is 0 is left untouched, its frame is not sent, no not-owner flag is raised, and the walk moves to its link.
- R4: With the stop policy bit at 1, such a descriptor halts the walk with no write-back and sets status bit 0.
- R5: A start pointer or link equal to 0x00000000 ends the walk and sets status bit 1.
- R6: The start level field (config bits [13:11]) gates MAC output. Level 0 means no wait, levels 1, 2 and 3 require 8, 16 and 24 buffered words, and any level with bit 2 set requires 32 words.
- R7: Once the final word of a frame is in the buffer, that frame drains whatever the level.
- R8: After a frame's first word has been taken by the MAC, output stays valid while the buffer holds data.
- R9: A `macCtrlDone` pulse sets status bit 2. A MAC transfer that leaves the buffer empty sets status bit 3.
- R10: Status bits stay set until a 1 is pulsed on the matching `stClr` bit. `irq` is the OR of status[0]&cfg[9], status[1]&cfg[8], status[2]&cfg[7] and status[3]&cfg[10].
- R11: The configuration register resets to zero. Bit 6 is reserved and always reads 0, so writing all ones reads back 0x3FBF.
- R12: A data read is requested only when the buffer has room for the whole burst. Once raised, a request holds its address and length until granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgWdata | input | 14 | Configuration write value |
| cfgRdata | output | 32 | Configuration read value |
| stClr | input | 4 | Write-one-to-clear pulses for status bits |
| status | output | 4 | Sticky event flags |
| irq | output | 1 | Masked interrupt |
| go | input | 1 | Start a descriptor walk |
| descBase | input | 32 | First descriptor address, sampled on `go` |
| busy | output | 1 | Walk in progress |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | Request is a single-word write |
| memAddr | output | 32 | Request byte address |
| memLen | output | 6 | Request length in words |
| memWdata | output | 32 | Write data |
| memGnt | input | 1 | Request accepted |
| memRvalid | input | 1 | Read word valid |
| memRdata | input | 32 | Read word |
| macData | output | 32 | Word to MAC FIFO |
| macLast | output | 1 | Final word of a frame |
| macValid | output | 1 | Word available |
| macReady | input | 1 | MAC accepts word |
| macCtrlDone | input | 1 | MAC finished a control packet |

## Verification
On every cycle the assertions check several local properties. Read lengths stay within the burst size and the words still owed. Pending requests do not change while they wait for a grant. The buffer never overflows. Status flags are never dropped without a clear pulse. A halt on a foreign descriptor always returns the engine to idle. The bench's scenarios cover what spans many cycles and the memory image. These are the skip policy leaving a descriptor untouched, write-back clearing the ownership flag, the exact word stream, the fill-level gating of `macValid` (tracked each cycle by a behavioural model, with random MAC back-pressure), the end-of-frame override, and the masking of the interrupt.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int BURST_W    = 5;
  localparam int LEN_W      = BURST_W + 1;
  localparam int CFG_W      = 14;
  localparam int DESC_WORDS = 3;
  localparam int ST_W       = 4;

  typedef struct packed {
    logic [2:0]         level;
    logic               enEmpty;
    logic               enNotOwn;
    logic               enNull;
    logic               enCtrl;
    logic               rsvd;
    logic               stopOnNotOwn;
    logic [BURST_W-1:0] burst;
  } cfg_t;

  typedef struct packed {
    logic        push;
    logic        pushLast;
    logic [31:0] pushData;
    logic        setNull;
    logic        setNotOwn;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DDAT, S_CHECK, S_BREQ, S_BDAT, S_WB
  } state_t;
endpackage

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  logic             go,
  input  logic [31:0]      descBase,
  input  logic [AW:0]      space,
  output strobe_t          stb,
  output logic             busy,
  output logic             memReq,
  output logic             memWrite,
  output logic [31:0]      memAddr,
  output logic [LEN_W-1:0] memLen,
  output logic [31:0]      memWdata,
  input  logic             memGnt,
  input  logic             memRvalid,
  input  logic [31:0]      memRdata
);
  state_t           state;
  logic [31:0]      curPtr, dOwnLen, dBuf, dNext, bufAddr;
  logic [15:0]      remain;
  logic [LEN_W-1:0] reqLen, wordCnt, blen, chunk;

  assign blen  = {1'b0, cfg.burst} + LEN_W'(1);
  assign chunk = (remain < 16'(blen)) ? remain[LEN_W-1:0] : blen;
  assign busy  = (state != S_IDLE);

  always_comb begin
    memReq   = 1'b0;
    memWrite = 1'b0;
    memAddr  = curPtr;
    memLen   = LEN_W'(DESC_WORDS);
    memWdata = {1'b0, dOwnLen[30:0]};
    stb      = '0;
    case (state)
      S_IDLE:  stb.setNull = go && (descBase == '0);
      S_DREQ:  memReq = 1'b1;
      S_CHECK: if (!dOwnLen[31]) begin
        stb.setNotOwn = cfg.stopOnNotOwn;
        stb.setNull   = !cfg.stopOnNotOwn && (dNext == '0);
      end
      S_BREQ: begin
        memAddr = bufAddr;
        memLen  = chunk;
        memReq  = (space >= (AW+1)'(chunk));
      end
      S_BDAT: begin
        stb.push     = memRvalid;
        stb.pushData = memRdata;
        stb.pushLast = (remain == 16'd1);
      end
      S_WB: begin
        memReq      = 1'b1;
        memWrite    = 1'b1;
        memLen      = LEN_W'(1);
        stb.setNull = memGnt && (dNext == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curPtr  <= '0;
      dOwnLen <= '0;
      dBuf    <= '0;
      dNext   <= '0;
      bufAddr <= '0;
      remain  <= '0;
      reqLen  <= '0;
      wordCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          curPtr <= descBase;
          if (descBase != '0) state <= S_DREQ;
        end
        S_DREQ: if (memGnt) begin
          wordCnt <= '0;
          state   <= S_DDAT;
        end
        S_DDAT: if (memRvalid) begin
          case (wordCnt)
            LEN_W'(0): dOwnLen <= memRdata;
            LEN_W'(1): dBuf    <= memRdata;
            default:   dNext   <= memRdata;
          endcase
          if (wordCnt == LEN_W'(DESC_WORDS - 1)) state <= S_CHECK;
          else wordCnt <= wordCnt + LEN_W'(1);
        end
        S_CHECK: if (!dOwnLen[31]) begin
          if (cfg.stopOnNotOwn) state <= S_IDLE;
          else begin
            curPtr <= dNext;
            state  <= (dNext == '0) ? S_IDLE : S_DREQ;
          end
        end else begin
          bufAddr <= dBuf;
          remain  <= dOwnLen[15:0];
          state   <= (dOwnLen[15:0] == '0) ? S_WB : S_BREQ;
        end
        S_BREQ: if (memReq && memGnt) begin
          reqLen  <= chunk;
          wordCnt <= '0;
          state   <= S_BDAT;
        end
        S_BDAT: if (memRvalid) begin
          remain  <= remain - 16'd1;
          bufAddr <= bufAddr + 32'd4;
          if (wordCnt == reqLen - LEN_W'(1))
            state <= (remain == 16'd1) ? S_WB : S_BREQ;
          else wordCnt <= wordCnt + LEN_W'(1);
        end
        S_WB: if (memGnt) begin
          curPtr <= dNext;
          state  <= (dNext == '0) ? S_IDLE : S_DREQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BREQ && memReq) |-> (memLen != '0 && memLen <= blen && 16'(memLen) <= remain)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> (memReq && $stable(memAddr) && $stable(memLen))); // R12
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.setNotOwn |=> !busy); // R4
  AST_NULL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.setNull |=> !busy); // R5
endmodule

// File: rtl/txdma_dpath.sv
module txdma_dpath
  import txdma_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWdata,
  output cfg_t             cfgOut,
  output logic [31:0]      cfgRdata,
  input  logic [ST_W-1:0]  stClr,
  output logic [ST_W-1:0]  status,
  output logic             irq,
  input  strobe_t          stb,
  output logic [AW:0]      space,
  output logic [31:0]      macData,
  output logic             macLast,
  output logic             macValid,
  input  logic             macReady,
  input  logic             macCtrlDone
);
  localparam int STEP = DEPTH / 8;

  cfg_t            cfgQ, cfgNext;
  logic [32:0]     store [DEPTH];
  logic [AW-1:0]   wrPtr, rdPtr;
  logic [AW:0]     count, endCnt, thr;
  logic            mid, pop;
  logic [ST_W-1:0] setV, enV;

  always_comb begin
    cfgNext      = cfg_t'(cfgWdata);
    cfgNext.rsvd = 1'b0;
  end
  assign cfgOut   = cfgQ;
  assign cfgRdata = {{(32-CFG_W){1'b0}}, cfgQ};

  assign thr      = cfgQ.level[2] ? (AW+1)'(4 * STEP)
                                  : (AW+1)'(int'(cfgQ.level[1:0]) * STEP);
  assign macValid = (count != '0) && (mid || endCnt != '0 || count >= thr);
  assign pop      = macValid && macReady;
  assign {macLast, macData} = store[rdPtr];
  assign space    = (AW+1)'(DEPTH) - count;

  assign setV = {pop && count == (AW+1)'(1) && !stb.push, macCtrlDone, stb.setNull, stb.setNotOwn};
  assign enV  = {cfgQ.enEmpty, cfgQ.enCtrl, cfgQ.enNull, cfgQ.enNotOwn};
  assign irq  = |(status & enV);

  always_ff @(posedge clk) begin
    if (stb.push) store[wrPtr] <= {stb.pushLast, stb.pushData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ   <= '0;
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      endCnt <= '0;
      mid    <= 1'b0;
      status <= '0;
    end else begin
      if (cfgWr) cfgQ <= cfgNext;
      if (stb.push) wrPtr <= wrPtr + AW'(1);
      if (pop) begin
        rdPtr <= rdPtr + AW'(1);
        mid   <= !macLast;
      end
      case ({stb.push, pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: ;
      endcase
      case ({stb.push && stb.pushLast, pop && macLast})
        2'b10:   endCnt <= endCnt + (AW+1)'(1);
        2'b01:   endCnt <= endCnt - (AW+1)'(1);
        default: ;
      endcase
      status <= (status & ~stClr) | setV;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (count < (AW+1)'(DEPTH))); // R12
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stClr == '0) |=> (($past(status) & ~status) == '0)); // R10
  AST_LAST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (macValid && macLast) |-> (endCnt != '0)); // R7
  AST_VALID_DATA: assert property (@(posedge clk) disable iff (!rstN)
    macValid |-> (count != '0 && count <= (AW+1)'(DEPTH))); // R8
endmodule

// File: rtl/txdma_fwd.sv
module txdma_fwd
  import txdma_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [31:0]      cfgRdata,
  input  logic [ST_W-1:0]  stClr,
  output logic [ST_W-1:0]  status,
  output logic             irq,
  input  logic             go,
  input  logic [31:0]      descBase,
  output logic             busy,
  output logic             memReq,
  output logic             memWrite,
  output logic [31:0]      memAddr,
  output logic [LEN_W-1:0] memLen,
  output logic [31:0]      memWdata,
  input  logic             memGnt,
  input  logic             memRvalid,
  input  logic [31:0]      memRdata,
  output logic [31:0]      macData,
  output logic             macLast,
  output logic             macValid,
  input  logic             macReady,
  input  logic             macCtrlDone
);
  localparam int AW = $clog2(DEPTH);

  cfg_t        cfg;
  strobe_t     stb;
  logic [AW:0] space;

  txdma_ctrl #(.DEPTH(DEPTH), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .go(go), .descBase(descBase),
    .space(space), .stb(stb), .busy(busy),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memLen(memLen),
    .memWdata(memWdata), .memGnt(memGnt), .memRvalid(memRvalid), .memRdata(memRdata)
  );

  txdma_dpath #(.DEPTH(DEPTH), .AW(AW)) uDpath (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWdata(cfgWdata), .cfgOut(cfg),
    .cfgRdata(cfgRdata), .stClr(stClr), .status(status), .irq(irq), .stb(stb),
    .space(space), .macData(macData), .macLast(macLast), .macValid(macValid),
    .macReady(macReady), .macCtrlDone(macCtrlDone)
  );
endmodule

// File: tb/sim_txdma_fwd.sv
module sim_txdma_fwd;
  localparam logic [31:0] DATA_BASE = 32'h8000;

  logic        clk = 0, rstN = 0, cfgWr = 0, go = 0, memGnt = 0, memRvalid = 0;
  logic        macReady = 0, macCtrlDone = 0;
  logic [13:0] cfgWdata = '0;
  logic [3:0]  stClr = '0;
  logic [31:0] descBase = '0, memRdata = '0;
  logic [31:0] cfgRdata, memAddr, memWdata, macData;
  logic [3:0]  status;
  logic [5:0]  memLen;
  logic        irq, busy, memReq, memWrite, macLast, macValid;

  txdma_fwd u0 (.*);

  always #4 clk = ~clk;

  int nChk = 0, nFail = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] expD[$];
  bit          expL[$];
  int          fLenQ[$], frmL[$];
  logic [31:0] frmA[$];
  int fill = 0, endsIn = 0, pushedCnt = 0, curFRem = 0, rdLeft = 0, lenD = 0;
  bit mid = 0, gntD = 0, wrD = 0;
  logic [31:0] curFAddr = '0, rdAddr = '0, addrD = '0;
  int curBurst = 0, curLvl = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int thrOf(input int lvl);
    return (lvl >= 4) ? 32 : lvl * 8;
  endfunction

  // cycle-accurate behavioural model, memory responder, MAC sink
  always @(negedge clk) begin
    bit expV;
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
    if (rstN) begin
      expV = fill > 0 && (mid || endsIn > 0 || fill >= thrOf(curLvl));
      chk(macValid === expV, "R6 R7 R8 output gating", 32'(macValid), 32'(expV));
    end
    macReady  = ($urandom_range(0, 9) < 7);
    memRvalid = 0;
    if (gntD) begin
      gntD = 0; memGnt = 0;
      if (!wrD) begin rdLeft = lenD; rdAddr = addrD; end
    end else if (rstN && memReq && rdLeft == 0) begin
      addrD = memAddr; lenD = int'(memLen); wrD = memWrite;
      if (memWrite) mem[memAddr] = memWdata;
      else if (memAddr >= DATA_BASE) begin
        if (curFRem == 0 && frmA.size() > 0) begin
          curFAddr = frmA.pop_front(); curFRem = frmL.pop_front();
        end
        chk(memAddr === curFAddr, "R1 burst address", memAddr, curFAddr);
        chk(int'(memLen) == ((curBurst + 1 < curFRem) ? curBurst + 1 : curFRem),
            "R1 burst length", 32'(memLen), 32'((curBurst + 1 < curFRem) ? curBurst + 1 : curFRem));
        chk(fill + int'(memLen) <= 64, "R12 room before request", 32'(fill + int'(memLen)), 32'd64);
        curFAddr = curFAddr + 32'(4 * int'(memLen));
        curFRem  = curFRem - int'(memLen);
      end
      memGnt = 1; gntD = 1;
    end
    if (rdLeft > 0) begin
      memRvalid = 1;
      memRdata  = mem.exists(rdAddr) ? mem[rdAddr] : 32'h0;
      if (rdAddr >= DATA_BASE) begin
        fill++; pushedCnt++;
        if (fLenQ.size() > 0 && pushedCnt == fLenQ[0]) begin
          endsIn++; pushedCnt = 0; void'(fLenQ.pop_front());
        end
      end
      rdAddr = rdAddr + 32'd4;
      rdLeft--;
    end
    if (rstN && macValid && macReady) begin
      if (expD.size() == 0) chk(0, "R2 unexpected word", macData, 32'h0);
      else begin
        logic [31:0] d; bit l;
        d = expD.pop_front(); l = expL.pop_front();
        chk(macData === d, "R2 word order", macData, d);
        chk(macLast === l, "R2 last marker", 32'(macLast), 32'(l));
      end
      fill--;
      if (macLast) begin endsIn--; mid = 0; end else mid = 1;
    end
  end

  task automatic wrCfg(input logic [13:0] v);
    @(negedge clk); cfgWdata = v; cfgWr = 1;
    @(negedge clk); cfgWr = 0; curBurst = int'(v[4:0]); curLvl = int'(v[13:11]);
  endtask

  task automatic clrSt(input logic [3:0] m);
    @(negedge clk); stClr = m;
    @(negedge clk); stClr = '0;
  endtask

  task automatic start(input logic [31:0] p);
    @(negedge clk); descBase = p; go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (busy || expD.size() != 0 || fill != 0);
    @(negedge clk);
  endtask

  task automatic addFrame(input logic [31:0] p, input bit own, input int len,
                          input logic [31:0] ba, input logic [31:0] nxt, input logic [31:0] seed);
    mem[p] = {own, 15'd0, 16'(len)}; mem[p + 4] = ba; mem[p + 8] = nxt;
    for (int i = 0; i < len; i++) begin
      mem[ba + 32'(4 * i)] = seed + 32'(i);
      if (own) begin expD.push_back(seed + 32'(i)); expL.push_back(i == len - 1); end
    end
    if (own) begin fLenQ.push_back(len); frmA.push_back(ba); frmL.push_back(len); end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(cfgRdata == 0, "R11 config reset", cfgRdata, 0);
    chk(status == 0, "R10 status reset", 32'(status), 0);
    chk(!irq && !busy && !macValid, "R11 idle outputs", {irq, busy, macValid}, 0);

    wrCfg(14'h3FFF);
    chk(cfgRdata == 32'h3FBF, "R11 reserved bit reads zero", cfgRdata, 32'h3FBF);
    wrCfg(14'h0000);

    // null start pointer, masked then unmasked
    start(32'h0);
    @(negedge clk);
    chk(status == 4'b0010, "R5 null start flag", 32'(status), 32'h2);
    chk(!busy, "R5 null start stays idle", 32'(busy), 0);
    chk(!irq, "R10 masked interrupt", 32'(irq), 0);
    wrCfg(14'h0100);
    chk(irq, "R10 null enable drives irq", 32'(irq), 1);
    clrSt(4'b0010);
    chk(status == 0 && !irq, "R10 write one to clear", {status, irq}, 0);

    // chain: owned, foreign (skip), owned with null link; burst 2, level 2
    wrCfg(14'h1101);
    addFrame(32'h1000, 1, 5,  32'h8000, 32'h1010, 32'hA000_0000);
    addFrame(32'h1010, 0, 4,  32'h9000, 32'h1020, 32'hB000_0000);
    addFrame(32'h1020, 1, 40, 32'hA000, 32'h0,    32'hC000_0000);
    start(32'h1000);
    waitDone();
    chk(mem[32'h1000] == 32'h0000_0005, "R2 write-back clears owner", mem[32'h1000], 32'h5);
    chk(mem[32'h1020] == 32'h0000_0028, "R2 second write-back", mem[32'h1020], 32'h28);
    chk(mem[32'h1010] == 32'h0000_0004, "R3 skipped descriptor untouched", mem[32'h1010], 32'h4);
    chk(status[0] == 0, "R3 skip raises no not-owner flag", 32'(status[0]), 0);
    chk(status[1] == 1, "R5 null link ends walk", 32'(status[1]), 1);
    chk(status[3] == 1, "R9 buffer empty flag", 32'(status[3]), 1);
    wrCfg(14'h0400);
    chk(irq, "R10 empty enable drives irq", 32'(irq), 1);
    clrSt(4'hF);

    // level 4 (32 words): short frame needs end override, long frame bursts 32 + 13
    wrCfg(14'h201F);
    addFrame(32'h1100, 1, 10, 32'hC000, 32'h1110, 32'hD000_0000);
    addFrame(32'h1110, 1, 45, 32'hD000, 32'h0,    32'hE000_0000);
    start(32'h1100);
    waitDone();
    chk(mem[32'h1110][31] == 0, "R7 frames delivered and released", 32'(mem[32'h1110][31]), 0);

    // no wait level, 3-word bursts, odd length
    wrCfg(14'h0002);
    addFrame(32'h1200, 1, 7, 32'hE000, 32'h0, 32'hF000_0000);
    start(32'h1200);
    waitDone();
    chk(mem[32'h1200] == 32'h7, "R6 level zero frame done", mem[32'h1200], 32'h7);
    clrSt(4'hF);

    // stop policy on a foreign descriptor
    wrCfg(14'h0220);
    addFrame(32'h1300, 0, 6, 32'hF000, 32'h1200, 32'h1234_0000);
    start(32'h1300);
    waitDone();
    chk(status == 4'b0001, "R4 not-owner flag", 32'(status), 32'h1);
    chk(irq, "R4 not-owner interrupt", 32'(irq), 1);
    chk(mem[32'h1300] == 32'h6, "R4 no write-back on stop", mem[32'h1300], 32'h6);
    clrSt(4'hF);

    // control packet completion
    wrCfg(14'h0080);
    @(negedge clk); macCtrlDone = 1;
    @(negedge clk); macCtrlDone = 0;
    chk(status == 4'b0100, "R9 control packet flag", 32'(status), 32'h4);
    chk(irq, "R10 control packet interrupt", 32'(irq), 1);
    clrSt(4'b0100);
    chk(status == 0 && !irq, "R10 clear control flag", {status, irq}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule